// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block is the internal write engine of a byte-wide flash array. A command decoder in front of it hands over single-cycle start requests that carry an operation code, a target address and a data byte. The engine then runs a timed busy interval and applies the operation to its array when that interval ends. The operations are byte program, whole-array erase and setting the boot-region lock.

While an operation runs, host reads return status instead of array contents. Bit 7 is a polling bit that settles to its final value only at completion. Bit 6 flips on every read. When the interval ends, the engine goes back to plain array reads without any action from the host.

Two protections are built in. The lowest `BOOT_DEPTH` locations can be locked against programming and erase. All writes are refused for `PWRUP_CYCLES` clocks after reset.

Top module: `flash_wr_engine`

## Requirements
- R1: After reset `busy` is 0 and every array location reads 0xFF.
- R2: A start request sampled before `PWRUP_CYCLES` clock edges have passed since reset is ignored: `busy` stays 0 and the array is unchanged.
- R3: A byte program stores the old byte ANDed with the supplied data, so programming never turns a 0 bit into a 1.
- R4: An accepted start raises `busy` on the same edge. `busy` stays high for exactly `PROG_CYCLES`, `ERASE_CYCLES` or `LOCK_CYCLES` clocks, depending on the operation. The array update happens on the edge where `busy` falls, and reads that follow return array data.
- R5: The operation codes on `startOp` are 2'b01 program, 2'b10 erase and 2'b11 lock. Code 2'b00 is ignored, and so is any start request sampled while `busy` is 1.
- R6: Erase writes 0xFF to every location. Once the lock is set, locations below `BOOT_DEPTH` keep their contents.
- R7: Once an earlier lock operation has completed, a program aimed below `BOOT_DEPTH` is refused: `busy` stays 0 and the byte is unchanged. Addresses at or above `BOOT_DEPTH` remain programmable. The lock stays set until reset.
- R8: A read sampled while a program is busy returns the inverse of bit 7 of the loaded data on bit 7, and 0 on bits 5..0.
- R9: A read sampled while an erase or lock operation is busy returns 0 on bit 7 and 0 on bits 5..0.
- R10: Bit 6 of status reads is 0 on the first read after a start is accepted, and it inverts on each later read while busy.
- R11: `rdEn` is sampled on a rising edge and `rdData` is loaded on that edge. `rdData` holds its value while `rdEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start request strobe from the command decoder |
| startOp | input | 2 | Operation code (see R5) |
| startAddr | input | ADDR_W | Byte address for program |
| startData | input | 8 | Data byte for program |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Registered read data or status |
| busy | output | 1 | High while a timed operation runs |

## Verification
The hardest state to reach is the lock-protected erase. The lock has to be set through a complete timed operation first, and then a full erase has to be run. Only after both can the bench show that boot bytes programmed earlier survived while main-array bytes went back to 0xFF. The bench reaches this by programming known bytes on both sides of the boundary before locking, then erasing. It follows with a random phase that keeps a shadow array and expects every program below the boundary to be refused. The start-while-busy rule is reached by sending an erase request one cycle into a program.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_LOCK  = 2'b11
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doProg;
    logic doErase;
    logic keepBoot;
    logic rdStatus;
    logic rdArray;
    logic restartToggle;
    logic pollBit7;
  } engStrobe_t;
endpackage

// File: rtl/flash_eng_ctrl.sv
module flash_eng_ctrl
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int BOOT_DEPTH   = 64,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int LOCK_CYCLES  = 20,
  parameter int PWRUP_CYCLES = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [1:0]        startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic              rdEn,
  output logic              busy,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output engStrobe_t        strb
);
  localparam int LONG_PE = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int LONGEST = (LONG_PE > LOCK_CYCLES) ? LONG_PE : LOCK_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int PWR_W   = $clog2(PWRUP_CYCLES + 1);
  localparam logic [ADDR_W-1:0] BOOT_LIMIT = ADDR_W'(BOOT_DEPTH);

  logic [PWR_W-1:0] pwrCnt;
  logic [CNT_W-1:0] busyCnt;
  logic [CNT_W-1:0] loadCnt;
  opKind_t          reqOp;
  opKind_t          curOp;
  logic             lockFlag;
  logic             pwrDone;
  logic             bootHit;
  logic             accept;
  logic             finish;

  assign reqOp   = opKind_t'(startOp);
  assign pwrDone = (pwrCnt == PWR_W'(PWRUP_CYCLES));
  assign bootHit = (startAddr < BOOT_LIMIT);
  assign accept  = startReq && !busy && pwrDone && (reqOp != OP_NONE) &&
                   !((reqOp == OP_PROG) && lockFlag && bootHit);
  assign finish  = busy && (busyCnt == '0);

  always_comb begin
    case (reqOp)
      OP_PROG:  loadCnt = CNT_W'(PROG_CYCLES - 1);
      OP_ERASE: loadCnt = CNT_W'(ERASE_CYCLES - 1);
      default:  loadCnt = CNT_W'(LOCK_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrCnt   <= '0;
      busy     <= 1'b0;
      busyCnt  <= '0;
      curOp    <= OP_NONE;
      lockFlag <= 1'b0;
      opAddr   <= '0;
      opData   <= '0;
    end else begin
      if (!pwrDone) pwrCnt <= pwrCnt + 1'b1;
      if (accept) begin
        busy    <= 1'b1;
        busyCnt <= loadCnt;
        curOp   <= reqOp;
        opAddr  <= startAddr;
        opData  <= startData;
      end else if (finish) begin
        busy <= 1'b0;
        if (curOp == OP_LOCK) lockFlag <= 1'b1;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.doProg        = finish && (curOp == OP_PROG);
    strb.doErase       = finish && (curOp == OP_ERASE);
    strb.keepBoot      = lockFlag;
    strb.rdStatus      = rdEn && busy;
    strb.rdArray       = rdEn && !busy;
    strb.restartToggle = accept;
    strb.pollBit7      = (curOp == OP_PROG) ? ~opData[DATA_W-1] : 1'b0;
  end
endmodule

// File: rtl/flash_eng_dpath.sv
module flash_eng_dpath
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int BOOT_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  engStrobe_t        strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.doProg) begin
      mem[opAddr] <= mem[opAddr] & opData;
    end else if (strb.doErase) begin
      for (int i = 0; i < DEPTH; i++)
        if (!(strb.keepBoot && (i < BOOT_DEPTH))) mem[i] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.restartToggle) toggle <= 1'b0;
      else if (strb.rdStatus) toggle <= ~toggle;
      if (strb.rdStatus) rdData <= {strb.pollBit7, toggle, {(DATA_W-2){1'b0}}};
      else if (strb.rdArray) rdData <= mem[rdAddr];
    end
  end
endmodule

// File: rtl/flash_wr_engine.sv
module flash_wr_engine
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int BOOT_DEPTH   = 64,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int LOCK_CYCLES  = 20,
  parameter int PWRUP_CYCLES = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [1:0]        startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        startData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy
);
  engStrobe_t        strb;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;

  flash_eng_ctrl #(
    .ADDR_W(ADDR_W), .BOOT_DEPTH(BOOT_DEPTH), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .LOCK_CYCLES(LOCK_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startOp(startOp),
    .startAddr(startAddr), .startData(startData), .rdEn(rdEn),
    .busy(busy), .opAddr(opAddr), .opData(opData), .strb(strb)
  );

  flash_eng_dpath #(.ADDR_W(ADDR_W), .BOOT_DEPTH(BOOT_DEPTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .opAddr(opAddr), .opData(opData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/flash_wr_engine_chk.sv
module flash_wr_engine_chk #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int LOCK_CYCLES  = 20,
  parameter int PWRUP_CYCLES = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       startReq,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       busy
);
  int busyLen;
  int sinceRst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyLen  <= 0;
      sinceRst <= 0;
    end else begin
      busyLen <= busy ? busyLen + 1 : 0;
      if (sinceRst < PWRUP_CYCLES) sinceRst <= sinceRst + 1;
    end
  end

  // R4: every busy window has one of the configured lengths
  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busyLen == PROG_CYCLES || busyLen == ERASE_CYCLES ||
                     busyLen == LOCK_CYCLES));

  // R2: no start takes effect during the power-up window
  a_r2_pwrup_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && sinceRst < PWRUP_CYCLES) |=> !busy);

  // R11: read data holds without a read strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdData));

  // R8, R9: low status bits are zero
  a_r8_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && busy) |=> (rdData[5:0] == 6'd0));
endmodule

bind flash_wr_engine flash_wr_engine_chk #(
  .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
  .LOCK_CYCLES(LOCK_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .startReq(startReq), .rdEn(rdEn),
  .rdData(rdData), .busy(busy)
);

// File: tb/sim_flash_wr_engine.sv
module sim_flash_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 9;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BOOT = 64;
  localparam int PROG_N = 8;
  localparam int ERASE_N = 40;
  localparam int LOCK_N = 20;
  localparam int PWR_N = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] startOp = 2'b00;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [7:0] startData = '0;
  logic rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic busy;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];
  logic lockModel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wr_engine #(
    .ADDR_W(ADDR_W), .BOOT_DEPTH(BOOT), .PROG_CYCLES(PROG_N),
    .ERASE_CYCLES(ERASE_N), .LOCK_CYCLES(LOCK_N), .PWRUP_CYCLES(PWR_N)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startOp(startOp),
    .startAddr(startAddr), .startData(startData), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int addr, input logic [7:0] d);
    startReq = 1'b1; startOp = op; startAddr = ADDR_W'(addr); startData = d;
    tick();
    startReq = 1'b0; startOp = 2'b00;
  endtask

  task automatic rd(input int addr, output logic [7:0] v);
    rdEn = 1'b1; rdAddr = ADDR_W'(addr);
    tick();
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin tick(); n++; end
  endtask

  function automatic logic progAllowed(input int addr);
    return !(lockModel && addr < BOOT);
  endfunction

  // program with full checking of accept, length and result
  task automatic progChk(input string req, input int addr, input logic [7:0] d);
    int n;
    logic [7:0] v;
    logic ok;
    ok = progAllowed(addr);
    issue(2'b01, addr, d);
    chk(req, busy, ok);
    waitIdle(n);
    if (ok) begin
      chk({req, " R4 len"}, n, PROG_N);
      model[addr] = model[addr] & d;
    end
    rd(addr, v);
    chk({req, " R3 data"}, v, model[addr]);
  endtask

  task automatic eraseModel();
    for (int i = 0; i < DEPTH; i++)
      if (!(lockModel && i < BOOT)) model[i] = 8'hFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    void'($urandom(32'h5EED_0042));
    repeat (3) tick();
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy", busy, 0);
    // R2 early start ignored
    issue(2'b01, 100, 8'h00);
    chk("R2 early start", busy, 0);
    rd(100, v);
    chk("R2 array unchanged", v, 8'hFF);
    repeat (PWR_N) tick();
    rd(0, v);             chk("R1 low addr", v, 8'hFF);
    rd(DEPTH - 1, v);     chk("R1 high addr", v, 8'hFF);

    // R3 AND behaviour
    progChk("R3 first", 100, 8'h3C);
    progChk("R3 second", 100, 8'hF5);

    // R8 R10 status during program, bit7 of data = 1
    issue(2'b01, 200, 8'h80);
    rd(0, v); chk("R8 R10 first status", v, 8'h00);
    rd(0, v); chk("R10 second status", v, 8'h40);
    rd(0, v); chk("R10 third status", v, 8'h00);
    waitIdle(n);
    chk("R4 len with reads", n + 3, PROG_N);
    model[200] = 8'h80;
    rd(200, v); chk("R4 back to array", v, 8'h80);
    // bit7 of data = 0
    issue(2'b01, 201, 8'h00);
    rd(0, v); chk("R8 poll inverse", v, 8'h80);
    rd(0, v); chk("R10 toggle", v, 8'hC0);
    waitIdle(n);
    model[201] = 8'h00;
    rd(201, v); chk("R8 true data after", v, 8'h00);

    // R11 hold
    rdAddr = ADDR_W'(100);
    repeat (3) tick();
    chk("R11 hold", rdData, 8'h00);

    // R5 start while busy and null opcode
    issue(2'b01, 300, 8'h0F);
    issue(2'b10, 0, 8'h00);
    waitIdle(n);
    chk("R5 busy ends at program length", n + 1, PROG_N);
    tick();
    chk("R5 no queued op", busy, 0);
    model[300] = 8'h0F;
    rd(100, v); chk("R5 erase ignored", v, model[100]);
    issue(2'b00, 5, 8'h00);
    chk("R5 null opcode", busy, 0);

    // random programs, unlocked
    for (int k = 0; k < 30; k++)
      progChk("R3 random", int'($urandom_range(DEPTH - 1, 0)), 8'($urandom));

    // R6 R9 erase unlocked
    issue(2'b10, 0, 8'h00);
    rd(0, v); chk("R9 erase status", v, 8'h00);
    rd(0, v); chk("R10 erase toggle", v, 8'h40);
    waitIdle(n);
    chk("R4 erase len", n + 2, ERASE_N);
    eraseModel();
    rd(10, v);  chk("R6 boot erased", v, 8'hFF);
    rd(300, v); chk("R6 main erased", v, 8'hFF);

    // prepare both sides then lock
    progChk("R3 boot prep", 10, 8'h12);
    progChk("R3 main prep", 400, 8'h56);
    issue(2'b11, 0, 8'h00);
    rd(0, v); chk("R9 lock status", v, 8'h00);
    waitIdle(n);
    chk("R4 lock len", n + 1, LOCK_N);
    lockModel = 1'b1;

    // R7 protection
    progChk("R7 boot refused", 10, 8'h00);
    progChk("R7 boundary refused", BOOT - 1, 8'h00);
    progChk("R7 boundary allowed", BOOT, 8'h0F);
    progChk("R7 main allowed", 400, 8'h06);

    // R6 erase with lock
    issue(2'b10, 0, 8'h00);
    waitIdle(n);
    eraseModel();
    rd(10, v);   chk("R6 boot kept", v, 8'h12);
    rd(400, v);  chk("R6 main erased locked", v, 8'hFF);
    rd(BOOT, v); chk("R6 boundary erased", v, 8'hFF);

    // relock is accepted and lock persists
    issue(2'b11, 0, 8'h00);
    chk("R7 relock accepted", busy, 1);
    waitIdle(n);
    for (int k = 0; k < 30; k++) begin
      int a;
      a = (k % 3 == 0) ? int'($urandom_range(BOOT - 1, 0)) : int'($urandom_range(DEPTH - 1, 0));
      progChk("R7 random", a, 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule